// File: doc/BRIEF.md
# Key Matrix Port with Keypad Interrupt

This block presents eight pressed-high key inputs to a processor as a two-by-four matrix behind one 8-bit port. The processor writes two group-select bits. Those bits choose whether the four keys in the low group, the four keys in the high group, or both groups are folded onto the low nibble of the read value. A pressed key reads as 0 there. The read value carries the select bits back in bits 5:4 and reads ones in bits 7:6.

The same selected nibble drives a keypad interrupt request. The block emits a one-cycle pulse each time the selected nibble changes from "no key pressed" to "at least one key pressed". The rest of the interrupt controller latches the pulse into its flag register as bit 4. Input debouncing belongs to another block.

The parameter `IDLE_ALL_PRESSED` chooses what the port reports when neither group is selected. The default reports no key pressed. The variant reports every key pressed.

Top module: `key_matrix_port`

## Requirements
- R1: After reset the select field is 2'b00 (both groups), `rd_data` is 8'hCF with no key pressed, and `key_irq` is low.
- R2: A write stores only `wr_data[5:4]` into the select field, in the clock edge where `wr_en` is high. The other written bits have no effect. Without a write the field holds.
- R3: With select 2'b01 (write 8'h10), `rd_data[3:0]` is the inverse of `key_down[3:0]`.
- R4: With select 2'b10 (write 8'h20), `rd_data[3:0]` is the inverse of `key_down[7:4]`.
- R5: With select 2'b00, `rd_data[3:0]` is the inverse of `key_down[3:0] | key_down[7:4]`.
- R6: With select 2'b11, `rd_data[3:0]` is 4'hF when `IDLE_ALL_PRESSED` is 0, and 4'h0 when it is 1, whatever the keys.
- R7: `rd_data[7:6]` always reads 2'b11, and `rd_data[5:4]` reads the stored select field.
- R8: When the selected nibble goes from all-zero to non-zero, `key_irq` is high for exactly one cycle, in the cycle after the first edge that sees the change. It stays low while the keys are held.
- R9: Keys that are pressed only in the unselected group never raise `key_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Port write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are used |
| key_down | input | 8 | Key states, 1 = pressed; [3:0] low group, [7:4] high group |
| rd_data | output | 8 | Port read value |
| key_irq | output | 1 | One-cycle keypad interrupt request pulse |

## Verification
The bench instantiates the block twice and drives both from the same inputs. One copy uses `IDLE_ALL_PRESSED` = 0 and the other uses 1. With two copies, the neither-selected case can be compared for both variants on a single write. The variant that reports every key pressed also exposes an interrupt that fires on a select change alone, with no change on the keys.

// File: rtl/key_matrix_port.sv
module key_matrix_port #(
  parameter bit IDLE_ALL_PRESSED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] key_down,
  output logic [7:0] rd_data,
  output logic       key_irq
);

  logic [1:0] sel_q;
  logic [3:0] nib;
  logic       any_now, any_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= 2'b00;
    else if (wr_en) sel_q <= wr_data[5:4];
  end

  always_comb begin
    unique case (sel_q)
      2'b01:   nib = key_down[3:0];
      2'b10:   nib = key_down[7:4];
      2'b00:   nib = key_down[3:0] | key_down[7:4];
      default: nib = IDLE_ALL_PRESSED ? 4'hF : 4'h0;
    endcase
  end

  assign any_now = |nib;
  assign rd_data = {2'b11, sel_q, ~nib};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      any_q <= any_now;
      irq_q <= any_now & ~any_q;
    end
  end

  assign key_irq = irq_q;

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[5:4] == $past(wr_data[5:4])); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data[5:4])); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |=> !key_irq); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |-> $past(rd_data[3:0]) != 4'hF); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] == 4'hF) |=> !key_irq); // R9

endmodule

// File: tb/sim_key_matrix_port.sv
`timescale 1ns/1ps
module sim_key_matrix_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] key_down = 8'h00;
  logic [7:0] rd0, rd1;
  logic irq0, irq1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  key_matrix_port #(.IDLE_ALL_PRESSED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .key_down(key_down), .rd_data(rd0), .key_irq(irq0));
  key_matrix_port #(.IDLE_ALL_PRESSED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .key_down(key_down), .rd_data(rd1), .key_irq(irq1));

  // {write value, keys, expected u0 read, requirement number}
  localparam logic [31:0] VEC [11] = '{
    {8'h10, 8'h01, 8'hDE, 8'd3},  // R3
    {8'h10, 8'hF0, 8'hDF, 8'd3},  // R3 high group invisible
    {8'h20, 8'hF0, 8'hE0, 8'd4},  // R4
    {8'h20, 8'h0A, 8'hEF, 8'd4},  // R4 low group invisible
    {8'h20, 8'h50, 8'hEA, 8'd4},  // R4
    {8'h00, 8'h21, 8'hCC, 8'd5},  // R5
    {8'h00, 8'h00, 8'hCF, 8'd5},  // R5
    {8'hCF, 8'h80, 8'hC7, 8'd2},  // R2 other bits ignored
    {8'h30, 8'hFF, 8'hFF, 8'd6},  // R6
    {8'hEF, 8'h30, 8'hEC, 8'd7},  // R7
    {8'h1F, 8'h0C, 8'hD3, 8'd2}   // R2
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic port_write(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 read", rd0, 8'hCF);
    check("R1 irq", {7'd0, irq0}, 8'h00);
    check("R1 variant read", rd1, 8'hCF);

    for (int i = 0; i < 11; i++) begin
      port_write(VEC[i][31:24]);
      key_down = VEC[i][23:16];
      #1;
      check($sformatf("R%0d vector %0d", VEC[i][7:0], i), rd0, VEC[i][15:8]);
    end

    port_write(8'h30);
    key_down = 8'h5A;
    #1;
    check("R6 idle none", rd0, 8'hFF);
    check("R6 idle all", rd1, 8'hF0);
    check("R7 upper bits", rd1 & 8'hF0, 8'hF0);

    key_down = 8'h00;
    port_write(8'h10);
    repeat (3) @(negedge clk);
    check("R8 quiet", {7'd0, irq0}, 8'h00);
    key_down = 8'h02;
    @(posedge clk); #1;
    check("R8 pulse", {7'd0, irq0}, 8'h01);
    @(posedge clk); #1;
    check("R8 one cycle", {7'd0, irq0}, 8'h00);
    repeat (3) @(posedge clk); #1;
    check("R8 held", {7'd0, irq0}, 8'h00);

    @(negedge clk);
    key_down = 8'h00;
    repeat (2) @(negedge clk);
    key_down = 8'hA0;
    repeat (4) @(posedge clk); #1;
    check("R9 unselected group", {7'd0, irq0}, 8'h00);

    @(negedge clk);
    key_down = 8'h00;
    repeat (3) @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h30;
    @(posedge clk); #1;
    check("R6 stays idle", {7'd0, irq0}, 8'h00);
    @(posedge clk); #1;
    check("R8 variant select pulse", {7'd0, irq1}, 8'h01);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 re-reset read", rd0, 8'hCF);
    check("R1 re-reset irq", {7'd0, irq0}, 8'h00);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule